// File: doc/BRIEF.md
# Register Field with Hardware-Side Strobes

This block is one storage field of a control/status register. Software reaches it through a read strobe and a write strobe that an outside address decoder has already qualified. Hardware reaches it through a next-value input and two write enables of opposite polarity. The field drives its stored value out to the hardware side and returns the same value on the software read-data port.

For each software access the field raises two single-cycle notices. One marks any software read and the other marks any software write. A parameter sets how the stored value evolves. In plain mode it holds whatever was written last. In one-shot mode a written 1 appears for one cycle and then drops. In bit-sticky mode each bit latches a hardware 1 until software clears it. In capture mode the first non-zero hardware word is held until software clears it.

In every mode a hardware update in a cycle takes precedence over a software write in that same cycle. This rule matters most for the sticky modes, because it ensures that an interrupt event arriving during a clear is not lost. The interface has no data stream, so every pin is a plain level or strobe and the block applies no back-pressure.

Top module: `field_reg`

## Requirements
- R1: After reset, `value` equals the parameter `RST_VAL` (default 0) in every mode.
- R2: `swacc` is 1 in exactly the cycles where `sw_rd` is 1. In every cycle `sw_rdata` equals the current `value`, with no delay.
- R3: `swmod` is 1 in exactly the cycles where `sw_wr` is 1.
- R4: In plain mode (MODE = FM_PLAIN), a software write with no hardware update makes `value` equal `sw_wdata` from the next cycle on.
- R5: A hardware update occurs when `hw_we` is 1 or `hw_wel` is 0. In plain and one-shot modes it loads `hw_next`, which is visible one cycle later. It overrides a software write made in the same cycle.
- R6: In plain mode, with no hardware update and no software write, `value` holds.
- R7: In one-shot mode (FM_PULSE), `value` shows the written word for exactly one cycle and returns to 0 in the next cycle unless a new write or hardware update arrives.
- R8: In bit-sticky mode (FM_STICKY_BIT), each bit of `hw_next` that is 1 during a hardware update sets the same bit of `value` from the next cycle. The bit stays 1 after `hw_next` falls.
- R9: In both sticky modes, a software write clears exactly those bits where `sw_wdata` is 1 (write-1-to-clear). Bits written 0 are unchanged.
- R10: In bit-sticky mode, a bit set by hardware and cleared by software in the same cycle ends up 1.
- R11: In capture mode (FM_STICKY_CAP), a hardware update with non-zero `hw_next` while `value` is 0 loads `hw_next`. While `value` is non-zero, later hardware values are ignored.
- R12: In capture mode, when a software clear zeroes `value` and a non-zero hardware update arrives in the same cycle, the hardware word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_rd | input | 1 | Software read strobe |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | W | Software write word (a clear mask in sticky modes) |
| sw_rdata | output | W | Software read word |
| hw_next | input | W | Hardware next value |
| hw_we | input | 1 | Hardware write enable, active high |
| hw_wel | input | 1 | Hardware write enable, active low |
| value | output | W | Stored field value |
| swacc | output | 1 | Software-access notice |
| swmod | output | 1 | Software-modify notice |

## Verification
`swacc`, `swmod` and `sw_rdata` are combinational and are due in the same cycle as their stimulus. The bench therefore checks them 1 ns after it drives inputs on the falling edge. `value` passes through one register, so its expected word is computed from the inputs of cycle N and compared at the falling edge that follows rising edge N+1. All four modes are instantiated side by side and run from the same stimulus. The stimulus combines directed precedence and clear cases with seeded random traffic.

// File: rtl/field_pkg.sv
package field_pkg;
  typedef enum logic [1:0] {
    FM_PLAIN      = 2'd0,
    FM_PULSE      = 2'd1,
    FM_STICKY_BIT = 2'd2,
    FM_STICKY_CAP = 2'd3
  } field_mode_e;
endpackage

// File: rtl/field_strobes.sv
module field_strobes (
  input  logic sw_rd,
  input  logic sw_wr,
  output logic swacc,
  output logic swmod
);
  // access notices are same-cycle images of the qualified strobes
  assign swacc = sw_rd;
  assign swmod = sw_wr;
endmodule

// File: rtl/field_hw_qual.sv
module field_hw_qual (
  input  logic hw_we,
  input  logic hw_wel,
  output logic hw_upd
);
  // either polarity of enable requests an update
  assign hw_upd = hw_we | ~hw_wel;
endmodule

// File: rtl/field_next.sv
module field_next #(
  parameter int W = 8,
  parameter field_pkg::field_mode_e MODE = field_pkg::FM_PLAIN
) (
  input  logic [W-1:0] cur,
  input  logic         hw_upd,
  input  logic [W-1:0] hw_next,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_wdata,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ZERO = '0;

  generate
    if (MODE == field_pkg::FM_PLAIN) begin : g_plain
      always_comb begin
        if (hw_upd)     nxt = hw_next;
        else if (sw_wr) nxt = sw_wdata;
        else            nxt = cur;
      end
    end else if (MODE == field_pkg::FM_PULSE) begin : g_pulse
      always_comb begin
        if (hw_upd)     nxt = hw_next;
        else if (sw_wr) nxt = sw_wdata;
        else            nxt = ZERO;
      end
    end else if (MODE == field_pkg::FM_STICKY_BIT) begin : g_sbit
      logic [W-1:0] clr_mask;
      logic [W-1:0] set_mask;
      always_comb begin
        clr_mask = sw_wr  ? sw_wdata : ZERO;
        set_mask = hw_upd ? hw_next  : ZERO;
        nxt      = (cur & ~clr_mask) | set_mask;
      end
    end else begin : g_scap
      logic [W-1:0] clr_mask;
      logic [W-1:0] kept;
      always_comb begin
        clr_mask = sw_wr ? sw_wdata : ZERO;
        kept     = cur & ~clr_mask;
        if (hw_upd && (hw_next != ZERO) && (kept == ZERO)) nxt = hw_next;
        else                                               nxt = kept;
      end
    end
  endgenerate
endmodule

// File: rtl/field_reg.sv
module field_reg #(
  parameter int W = 8,
  parameter field_pkg::field_mode_e MODE = field_pkg::FM_PLAIN,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rd,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_wdata,
  output logic [W-1:0] sw_rdata,
  input  logic [W-1:0] hw_next,
  input  logic         hw_we,
  input  logic         hw_wel,
  output logic [W-1:0] value,
  output logic         swacc,
  output logic         swmod
);
  logic         hw_upd;
  logic [W-1:0] nxt;
  logic [W-1:0] q;

  field_strobes u_strb (
    .sw_rd (sw_rd),
    .sw_wr (sw_wr),
    .swacc (swacc),
    .swmod (swmod)
  );

  field_hw_qual u_qual (
    .hw_we  (hw_we),
    .hw_wel (hw_wel),
    .hw_upd (hw_upd)
  );

  field_next #(.W(W), .MODE(MODE)) u_next (
    .cur      (q),
    .hw_upd   (hw_upd),
    .hw_next  (hw_next),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .nxt      (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= nxt;
  end

  assign value    = q;
  assign sw_rdata = q;
endmodule

// File: rtl/field_reg_chk.sv
module field_reg_chk #(
  parameter int W = 8,
  parameter field_pkg::field_mode_e MODE = field_pkg::FM_PLAIN
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sw_wr,
  input logic [W-1:0] sw_wdata,
  input logic [W-1:0] hw_next,
  input logic         hw_we,
  input logic         hw_wel,
  input logic [W-1:0] value
);
  localparam logic [W-1:0] ZERO = '0;
  localparam bit IS_PLAIN = (MODE == field_pkg::FM_PLAIN);
  localparam bit IS_PULSE = (MODE == field_pkg::FM_PULSE);
  localparam bit IS_SBIT  = (MODE == field_pkg::FM_STICKY_BIT);
  localparam bit IS_SCAP  = (MODE == field_pkg::FM_STICKY_CAP);

  logic upd;
  assign upd = hw_we || !hw_wel;

  a_r4_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_PLAIN && sw_wr && !upd) |=> (value == $past(sw_wdata)));

  a_r5_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((IS_PLAIN || IS_PULSE) && upd) |=> (value == $past(hw_next)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_PLAIN && !upd && !sw_wr) |=> $stable(value));

  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_PULSE && !upd && !sw_wr) |=> (value == ZERO));

  a_r8_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_SBIT && !sw_wr) |=> ((value & $past(value)) == $past(value)));

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_SBIT && upd) |=> ((value & $past(hw_next)) == $past(hw_next)));

  a_r11_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_SCAP && (value != ZERO) && !sw_wr) |=> $stable(value));
endmodule

bind field_reg field_reg_chk #(.W(W), .MODE(MODE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sw_wr    (sw_wr),
  .sw_wdata (sw_wdata),
  .hw_next  (hw_next),
  .hw_we    (hw_we),
  .hw_wel   (hw_wel),
  .value    (value)
);

// File: tb/sim_field_reg.sv
`timescale 1ns/1ps
module sim_field_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rd = 1'b0, sw_wr = 1'b0, hw_we = 1'b0, hw_wel = 1'b1;
  logic [W-1:0] sw_wdata = '0, hw_next = '0;

  logic [W-1:0] val   [4];
  logic [W-1:0] rdat  [4];
  logic         acc   [4];
  logic         mdf   [4];
  logic [W-1:0] exp_v [4];

  int n_chk = 0, n_bad = 0;
  string last_tag = "R1";

  always #4 clk = ~clk;

  field_reg #(.W(W), .MODE(field_pkg::FM_PLAIN)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_rdata(rdat[0]), .hw_next(hw_next), .hw_we(hw_we), .hw_wel(hw_wel),
    .value(val[0]), .swacc(acc[0]), .swmod(mdf[0]));
  field_reg #(.W(W), .MODE(field_pkg::FM_PULSE)) u1 (
    .clk(clk), .rst_n(rst_n), .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_rdata(rdat[1]), .hw_next(hw_next), .hw_we(hw_we), .hw_wel(hw_wel),
    .value(val[1]), .swacc(acc[1]), .swmod(mdf[1]));
  field_reg #(.W(W), .MODE(field_pkg::FM_STICKY_BIT)) u2 (
    .clk(clk), .rst_n(rst_n), .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_rdata(rdat[2]), .hw_next(hw_next), .hw_we(hw_we), .hw_wel(hw_wel),
    .value(val[2]), .swacc(acc[2]), .swmod(mdf[2]));
  field_reg #(.W(W), .MODE(field_pkg::FM_STICKY_CAP)) u3 (
    .clk(clk), .rst_n(rst_n), .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_rdata(rdat[3]), .hw_next(hw_next), .hw_we(hw_we), .hw_wel(hw_wel),
    .value(val[3]), .swacc(acc[3]), .swmod(mdf[3]));

  // reference behaviour of each mode, taken from the requirements
  function automatic logic [W-1:0] model(input int m, input logic [W-1:0] cur,
      input logic wr, input logic [W-1:0] wd, input logic upd, input logic [W-1:0] nx);
    logic [W-1:0] clr, kept;
    clr  = wr ? wd : '0;
    kept = cur & ~clr;
    case (m)
      0: return upd ? nx : (wr ? wd : cur);                 // R4 R5 R6
      1: return upd ? nx : (wr ? wd : '0);                  // R7
      2: return kept | (upd ? nx : '0);                     // R8 R9 R10
      default: return (upd && nx != '0 && kept == '0) ? nx : kept; // R11 R12
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R4/R6";
      1: return "R7";
      2: return "R8/R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, ex);
    end
  endtask

  task automatic cyc(input logic rd, input logic wr, input logic [W-1:0] wd,
                     input logic we, input logic wel, input logic [W-1:0] nx, input string tg);
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      check($sformatf("%s mode%0d %s", last_tag, m, mode_tag(m)), val[m], exp_v[m]);
    sw_rd = rd; sw_wr = wr; sw_wdata = wd; hw_we = we; hw_wel = wel; hw_next = nx;
    #1;
    for (int m = 0; m < 4; m++) begin
      check("R2 swacc", {7'd0, acc[m]}, {7'd0, rd});
      check("R2 rdata", rdat[m], val[m]);
      check("R3 swmod", {7'd0, mdf[m]}, {7'd0, wr});
    end
    for (int m = 0; m < 4; m++)
      exp_v[m] = model(m, exp_v[m], wr, wd, we | ~wel, nx);
    last_tag = tg;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int m = 0; m < 4; m++) exp_v[m] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state checked at the first cycle
    cyc(0, 0, 8'h00, 0, 1, 8'h00, "R6");
    cyc(1, 0, 8'h00, 0, 1, 8'h77, "R2");
    // R4 software write, then R5 hardware wins over concurrent write
    cyc(0, 1, 8'h3C, 0, 1, 8'h00, "R4");
    cyc(0, 1, 8'h11, 1, 1, 8'hA5, "R5");
    cyc(0, 1, 8'h22, 0, 0, 8'h5A, "R5");
    // R7 one-shot fall back
    cyc(0, 1, 8'h01, 0, 1, 8'h00, "R7");
    cyc(0, 0, 8'h00, 0, 1, 8'h00, "R7");
    // R8 sticky set then input falls
    cyc(0, 1, 8'hFF, 0, 1, 8'h00, "R9");
    cyc(0, 0, 8'h00, 1, 1, 8'h81, "R8");
    cyc(0, 0, 8'h00, 1, 1, 8'h00, "R8");
    // R11 later value ignored
    cyc(0, 0, 8'h00, 1, 1, 8'h0F, "R11");
    // R9 partial clear; R10 set during clear wins
    cyc(0, 1, 8'h01, 0, 1, 8'h00, "R9");
    cyc(0, 1, 8'h80, 1, 1, 8'h80, "R10");
    cyc(0, 0, 8'h00, 0, 1, 8'h00, "R10");
    // R12 clear to zero with simultaneous capture
    cyc(0, 1, 8'hFF, 0, 0, 8'h44, "R12");
    cyc(0, 0, 8'h00, 0, 1, 8'h00, "R12");
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] nx;
      nx = ($urandom % 3 == 0) ? W'($urandom) : '0;
      cyc(1'($urandom % 4 == 0), 1'($urandom % 4 == 0), W'($urandom),
          1'($urandom % 5 == 0), 1'($urandom % 6 != 0), nx, "R5/R9");
    end
    cyc(0, 0, 8'h00, 0, 1, 8'h00, "R6");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule